// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is one 32-bit count-down timer behind a small word-indexed register file. A separate timer clock-enable input paces the count through a prescaler that divides by 1, 16 or 256. Software picks one of three counting modes, selects 16-bit or 32-bit counting, and chooses between two ways of setting the reload value. One writes the counter at once. The other only stages a value that the counter picks up the next time it reloads.

Each time the count runs out, a sticky raw interrupt flag is set. Software clears it by writing the clear word. The interrupt line and the masked status both carry the flag gated by an enable bit. Reads are combinational from the word index.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control word reads 0x20: interrupt enable set, counter stopped, 16-bit, free-running mode. The value word reads 0 and `irqOut` is low.
- R2: Control bits [3:2] select the prescale: 00 decrements on every enabled timer tick, 01 on every 16th tick, 10 on every 256th tick, and 11 acts as 00. The prescaler advances only while `tickEn` is high. Any control write clears it.
- R3: The read word index map is 0 reload value, 1 current count, 2 control (bits 7:0, zero-extended), 4 raw flag in bit 0, 5 masked flag in bit 0, 6 reload value. Indices 3 and 7 through 15 read zero.
- R4: A write to index 0 sets the reload value and loads the counter in the same clock. In free-running mode the counter is loaded with the width maximum instead.
- R5: A write to index 6 changes only the reload value. The counter keeps counting, and the new value is used at the next reload.
- R6: With control bit 0 (one-shot) and bit 6 (periodic) both clear, the counter reloads to 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode (bit 1 set).
- R7: In periodic mode (bit 6 set, bit 0 clear), a counter that has reached zero is reloaded from the reload value on the next clock, whether or not a tick arrives.
- R8: In one-shot mode (bit 0 set, taking precedence over bit 6), the counter stops at zero after expiring once and raises the flag only once.
- R9: In 16-bit mode only bits 15:0 count and wrap. The value word returns those bits zero-extended.
- R10: A decrement that takes the active count from 1 to 0 sets the raw flag. Any write to index 3 clears it. If a set and a clear land in the same clock, the set wins.
- R11: `irqOut` and the masked flag both equal the raw flag ANDed with control bit 5. They read 0 while bit 5 is clear.
- R12: Writes to index 1 have no effect on the counter.
- R13: A control write with bit 7 set reloads the counter from the current limit on the following clock. While bit 7 is clear, the counter holds its value except on index 0 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer clock enable, one pulse per timer tick |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the word at `addr` |
| irqOut | output | 1 | Masked interrupt |

## Verification
The bound checker watches several rules on every clock. The masked status word must agree with the interrupt line, and the raw flag must agree with it whenever the interrupt is enabled. A stopped counter must never move, a one-shot counter at zero must stay there, and a 16-bit value read must always come back with its upper half zero. The scenarios are needed for everything that depends on elapsed time: the expiry latency under each prescale setting, a staged reload being picked up at the restart, the single firing in one-shot mode, and the wrap to the width maximum in free-running mode. The bench's cycle model covers these, along with clear-versus-set ordering under mixed traffic.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTRL_W        = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  localparam int CTL_ONESHOT   = 0;
  localparam int CTL_WIDE      = 1;
  localparam int CTL_DIV_LO    = 2;
  localparam int CTL_DIV_HI    = 3;
  localparam int CTL_IE        = 5;
  localparam int CTL_PERIODIC  = 6;
  localparam int CTL_EN        = 7;

  localparam int IDX_LOAD      = 0;
  localparam int IDX_VALUE     = 1;
  localparam int IDX_CTRL      = 2;
  localparam int IDX_ICLR      = 3;
  localparam int IDX_RAW       = 4;
  localparam int IDX_MASKED    = 5;
  localparam int IDX_BGLOAD    = 6;

  localparam int DIV16_BITS    = 4;
  localparam int DIV256_BITS   = 8;

  typedef struct packed {
    logic loadWr;
    logic bgWr;
    logic restart;
    logic tick;
    logic clrFlag;
    logic enable;
    logic oneShot;
    logic freeRun;
    logic wide;
  } dpCmd_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrlData,
  output dpCmd_t            cmd,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              restartQ
);
  logic [PRE_W-1:0] psQ;
  logic             ctrlWr;
  logic             divHit;

  assign ctrlWr = wrEn && (addr == ADDR_W'(IDX_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= CTRL_RESET;
      restartQ <= 1'b0;
      psQ      <= '0;
    end else begin
      restartQ <= ctrlWr && ctrlData[CTL_EN];
      if (ctrlWr) begin
        ctrlQ <= ctrlData;
        psQ   <= '0;
      end else if (tickEn) begin
        psQ <= psQ + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ctrlQ[CTL_DIV_HI:CTL_DIV_LO])
      2'b01:   divHit = &psQ[DIV16_BITS-1:0];
      2'b10:   divHit = &psQ[DIV256_BITS-1:0];
      default: divHit = 1'b1;
    endcase
  end

  always_comb begin
    cmd.loadWr  = wrEn && (addr == ADDR_W'(IDX_LOAD));
    cmd.bgWr    = wrEn && (addr == ADDR_W'(IDX_BGLOAD));
    cmd.clrFlag = wrEn && (addr == ADDR_W'(IDX_ICLR));
    cmd.restart = restartQ;
    cmd.enable  = ctrlQ[CTL_EN];
    cmd.oneShot = ctrlQ[CTL_ONESHOT];
    cmd.freeRun = !ctrlQ[CTL_ONESHOT] && !ctrlQ[CTL_PERIODIC];
    cmd.wide    = ctrlQ[CTL_WIDE];
    cmd.tick    = tickEn && ctrlQ[CTL_EN] && !ctrlWr && divHit;
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntView,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] reloadQ,
  output logic              rawFlag
);
  localparam int HIGH_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] limit;
  logic [DATA_W-1:0] decCnt;
  logic              isZero;
  logic              isOne;
  logic              fire;

  assign widthMask = cmd.wide ? {DATA_W{1'b1}} : {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}};
  assign cntView   = cntQ & widthMask;
  assign isZero    = (cntView == '0);
  assign isOne     = (cntView == DATA_W'(1));
  assign limit     = cmd.freeRun ? widthMask : reloadQ;
  assign decCnt    = cmd.wide ? (cntQ - 1'b1)
                              : {cntQ[DATA_W-1:NARROW_W], cntQ[NARROW_W-1:0] - 1'b1};
  assign fire      = cmd.tick && isOne && !cmd.loadWr && !cmd.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
      cntQ    <= '0;
      rawFlag <= 1'b0;
    end else begin
      if (cmd.loadWr || cmd.bgWr) reloadQ <= wrData;

      if (cmd.loadWr)
        cntQ <= cmd.freeRun ? widthMask : wrData;
      else if (cmd.restart)
        cntQ <= limit;
      else if (cmd.enable && isZero && !cmd.oneShot)
        cntQ <= limit;
      else if (cmd.tick && !isZero)
        cntQ <= decCnt;

      if (fire)             rawFlag <= 1'b1;
      else if (cmd.clrFlag) rawFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  dpCmd_t            cmd;
  logic [CTRL_W-1:0] ctrlQ;
  logic              restartQ;
  logic [DATA_W-1:0] cntView;
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] reloadQ;
  logic              rawFlag;
  logic              maskedFlag;

  timer_ctrl #(.ADDR_W(ADDR_W), .PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .ctrlData(wrData[CTRL_W-1:0]), .cmd(cmd), .ctrlQ(ctrlQ), .restartQ(restartQ)
  );

  timer_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .cntView(cntView), .cntQ(cntQ), .reloadQ(reloadQ), .rawFlag(rawFlag)
  );

  assign maskedFlag = rawFlag && ctrlQ[CTL_IE];
  assign irqOut     = maskedFlag;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(IDX_LOAD) || addr == ADDR_W'(IDX_BGLOAD)) rdData = reloadQ;
    else if (addr == ADDR_W'(IDX_VALUE))  rdData = cntView;
    else if (addr == ADDR_W'(IDX_CTRL))   rdData = DATA_W'(ctrlQ);
    else if (addr == ADDR_W'(IDX_RAW))    rdData = DATA_W'(rawFlag);
    else if (addr == ADDR_W'(IDX_MASKED)) rdData = DATA_W'(maskedFlag);
  end
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk
  import timer_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic [CTRL_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] cntQ,
  input logic              restartQ
);
  logic loadWr;
  logic cntAtZero;

  assign loadWr    = wrEn && (addr == ADDR_W'(IDX_LOAD));
  assign cntAtZero = ctrlQ[CTL_WIDE] ? (cntQ == '0) : (cntQ[NARROW_W-1:0] == '0);

  assert_masked_matches_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(IDX_MASKED)) |-> (rdData == DATA_W'(irqOut)));

  assert_raw_drives_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTL_IE] && addr == ADDR_W'(IDX_RAW)) |-> (rdData[0] == irqOut));

  assert_narrow_zero_ext_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[CTL_WIDE] && addr == ADDR_W'(IDX_VALUE)) |-> (rdData[DATA_W-1:NARROW_W] == '0));

  assert_stopped_holds_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[CTL_EN] && !restartQ && !loadWr) |=> $stable(cntQ));

  assert_oneshot_parks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTL_EN] && ctrlQ[CTL_ONESHOT] && cntAtZero && !restartQ && !loadWr) |=> $stable(cntQ));
endmodule

bind countdown_timer countdown_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .irqOut(irqOut), .ctrlQ(ctrlQ), .cntQ(cntQ), .restartQ(restartQ)
);

// File: tb/countdown_timer_tb_top.sv
`timescale 1ns/1ps
module countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'd1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  countdown_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // behavioural reference state
  logic [7:0]  mCtrl;
  logic [31:0] mReload, mCount;
  logic        mFlag, mRestart;
  int          mPs;

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    logic [31:0] mask;
    mask = mCtrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    case (a)
      4'd0, 4'd6: return mReload;
      4'd1:       return mCount & mask;
      4'd2:       return {24'd0, mCtrl};
      4'd4:       return {31'd0, mFlag};
      4'd5:       return {31'd0, mFlag & mCtrl[5]};
      default:    return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 8'h20; mReload = 0; mCount = 0; mFlag = 0; mRestart = 0; mPs = 0;
    end else begin
      logic [31:0] mask, mc, lim;
      logic en, one, free, ctrlWr, loadWr, bgWr, clrWr, okDiv, strobe, fire;
      en = mCtrl[7]; one = mCtrl[0]; free = !mCtrl[0] && !mCtrl[6];
      mask = mCtrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      mc = mCount & mask;
      lim = free ? mask : mReload;
      ctrlWr = wrEn && addr == 2; loadWr = wrEn && addr == 0;
      bgWr = wrEn && addr == 6; clrWr = wrEn && addr == 3;
      case (mCtrl[3:2])
        2'b01:   okDiv = (mPs % 16) == 15;
        2'b10:   okDiv = (mPs % 256) == 255;
        default: okDiv = 1;
      endcase
      strobe = tickEn && en && !ctrlWr && okDiv;
      fire = strobe && mc == 1 && !loadWr && !mRestart;
      if (loadWr) mCount = free ? mask : wrData;
      else if (mRestart) mCount = lim;
      else if (en && mc == 0 && !one) mCount = lim;
      else if (strobe && mc != 0) begin
        if (mCtrl[1]) mCount = mCount - 1;
        else mCount = {mCount[31:16], mCount[15:0] - 16'd1};
      end
      if (loadWr || bgWr) mReload = wrData;
      if (fire) mFlag = 1; else if (clrWr) mFlag = 0;
      mRestart = ctrlWr && wrData[7];
      if (ctrlWr) begin mCtrl = wrData[7:0]; mPs = 0; end
      else if (tickEn) mPs = (mPs + 1) % 256;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 read data vs model", rdData, modelRead(addr));
      check("R11 irq vs model", {31'd0, irqOut}, {31'd0, mFlag & mCtrl[5]});
    end
  end

  task automatic idle(input int n);
    wrEn = 0; addr = 4'd1;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0; addr = 4'd1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    wrEn = 0; addr = a;
    @(negedge clk); v = rdData;
    @(posedge clk); #1;
    addr = 4'd1;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 2000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic prescaleRun(input logic [7:0] ctl, input int expN, input string req);
    int n;
    wr(4'd2, 32'h60); wr(4'd3, 0); wr(4'd0, 2);
    wr(4'd2, {24'd0, ctl});
    waitIrq(n);
    check(req, n, expN);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    idle(1);
    // R1 reset state
    rd(4'd2, v); check("R1 control after reset", v, 32'h20);
    rd(4'd1, v); check("R1 value after reset", v, 0);
    check("R1 irq after reset", {31'd0, irqOut}, 0);
    // R3 undefined indices
    rd(4'd3, v); check("R3 index 3 reads zero", v, 0);
    rd(4'd7, v); check("R3 index 7 reads zero", v, 0);
    rd(4'd15, v); check("R3 index 15 reads zero", v, 0);
    // R4 immediate load
    wr(4'd2, 32'h60); wr(4'd0, 100);
    rd(4'd1, v); check("R4 load sets counter", v, 100);
    rd(4'd0, v); check("R4 load sets reload", v, 100);
    // R5 background load
    wr(4'd6, 50);
    rd(4'd6, v); check("R5 bg load reload value", v, 50);
    rd(4'd1, v); check("R5 bg load leaves counter", v, 100);
    // R12 value write ignored
    wr(4'd1, 7);
    rd(4'd1, v); check("R12 value write ignored", v, 100);
    // R7 / R10 periodic expiry, staged reload picked up at restart
    wr(4'd2, 32'hE0);
    waitIrq(n); check("R7 periodic expiry latency", n, 51);
    rd(4'd4, v); check("R10 raw flag set", v, 1);
    rd(4'd5, v); check("R11 masked flag set", v, 1);
    wr(4'd3, 0);
    rd(4'd4, v); check("R10 clear write", v, 0);
    // R11 masking
    wr(4'd2, 32'hC0); idle(60);
    rd(4'd5, v); check("R11 masked reads zero", v, 0);
    rd(4'd4, v); check("R11 raw still set", v, 1);
    check("R11 irq low when masked", {31'd0, irqOut}, 0);
    // R8 one-shot, precedence over periodic
    wr(4'd2, 32'hE1); wr(4'd0, 5); wr(4'd3, 0); idle(20);
    rd(4'd1, v); check("R8 one-shot parks at zero", v, 0);
    rd(4'd4, v); check("R8 one-shot fired", v, 1);
    wr(4'd3, 0); idle(20);
    rd(4'd4, v); check("R8 fires only once", v, 0);
    rd(4'd1, v); check("R8 still at zero", v, 0);
    // R6 free-running maxima, R13 restart on enable
    wr(4'd2, 32'hA0); idle(1);
    rd(4'd1, v); check("R6 16-bit free-run start", v, 32'h0000_FFFF);
    wr(4'd2, 32'hA2); idle(1);
    rd(4'd1, v); check("R6 32-bit free-run start", v, 32'hFFFF_FFFF);
    // R9 narrow view
    wr(4'd2, 32'h60); wr(4'd0, 32'h0003_0002);
    rd(4'd1, v); check("R9 narrow value zero-extended", v, 2);
    rd(4'd0, v); check("R3 reload reads full word", v, 32'h0003_0002);
    // R2 prescale settings
    prescaleRun(8'hE4, 32, "R2 divide by 16");
    prescaleRun(8'hE8, 512, "R2 divide by 256");
    prescaleRun(8'hEC, 3, "R2 select 11 as divide by 1");
    prescaleRun(8'hE0, 3, "R2 divide by 1");
    // R2 tick gating
    wr(4'd2, 32'h60); wr(4'd3, 0); wr(4'd0, 2);
    tickEn = 0;
    wr(4'd2, 32'hE0); idle(10);
    rd(4'd1, v); check("R2 no count without tickEn", v, 2);
    tickEn = 1; idle(30);
    // R13 stopped counter holds
    wr(4'd2, 32'h60);
    rd(4'd1, v); idle(5); rd(4'd1, v2);
    check("R13 stopped counter holds", v2, v);
    // mixed traffic under the model, including clear racing expiry (R10)
    wr(4'd0, 3); wr(4'd2, 32'hE0);
    for (int i = 0; i < 200; i++) begin
      tickEn = (i % 3) != 0;
      if (i % 4 == 0) wr(4'd3, 0);
      else if (i % 37 == 0) wr(4'd6, i % 5);
      else idle(1);
    end
    tickEn = 1; idle(5);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule